// File: doc/BRIEF.md
# Secondary Cascaded Interrupt Controller

This block collects up to 28 peripheral interrupt lines and folds them into a single cascade request for a primary interrupt controller. Each source has three settings: an enable bit, a trigger-type bit that chooses level or edge detection, and a polarity bit. Input lines pass through a two-flop synchroniser. Edge events are held in a per-source latch until software acknowledges them. Level sources follow their input, with the polarity applied.

Firmware uses a 32-bit register port with a single-cycle write strobe and a combinational read. The enable mask can only be changed through separate write-one-to-set and write-one-to-clear locations. A software-trigger register can raise any source directly. Two status words are readable: pending before masking and pending after masking. A priority encoder reports the lowest-numbered enabled pending source, so that the service routine can go straight to it. The number of sources is a parameter. A reduced build of 23 sources is one such setting.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_out` is 0 and `top_vld` is 0.
- R2: A write to word 0x0C sets each enable bit that is written as 1. A write to word 0x08 clears each enable bit that is written as 1. Bits written as 0 stay as they were. Word 0x04 reads the enable mask, and writes to 0x04 have no effect.
- R3: Words 0x00 (route), 0x10 (mode: 1 = edge, 0 = level), 0x14 (invert: 1 = active-low / falling) and 0x18 (guard) store the written value and read it back. Bits at or above NUM_SRC always read 0.
- R4: A level-mode source is pending while input XOR invert is 1. A change on the input reaches raw status (word 0x24) two clock edges after it is applied, and not after one.
- R5: An edge-mode source latches pending on a 0-to-1 transition of input XOR invert. It stays pending after the input returns to idle.
- R6: Writing 1 to a bit of word 0x28 clears that source's edge latch. For a level-mode source the write has no lasting effect.
- R7: If a new edge and an acknowledge of the same source fall in the same cycle, the source stays pending.
- R8: A 1 in word 0x2C makes that source pending, as an active-high level, whatever its mode.
- R9: Raw status (0x24) holds the pending bits before masking. Masked status (0x1C) equals raw AND enable. Word 0x20 reads 0.
- R10: `irq_out` is 1 exactly when masked status is nonzero.
- R11: `top_vld` equals `irq_out`. When it is 1, `top_idx` is the lowest bit index set in masked status.
- R12: The write-only words 0x08, 0x0C and 0x28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Asynchronous peripheral interrupt lines |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| irq_out | output | 1 | Cascade request to the primary controller |
| top_idx | output | $clog2(NUM_SRC) | Index of the lowest enabled pending source |
| top_vld | output | 1 | `top_idx` is meaningful |

## Verification
The bench targets cycle-level collisions. It places an acknowledge write in exactly the cycle a new edge is detected. A design in which the clear wins would lose that interrupt. It times the synchroniser depth on both sides: a design with one flop too few or too many shows raw status one cycle early or late. It also changes polarity on an idle edge source. A design that takes the polarity change as an edge would latch a spurious event. Random sequences of mask, mode, polarity, acknowledge and software-trigger writes are checked against a reference model. These catch a priority encoder that picks the highest bit, a mask applied to raw status, and storage that leaks bits above the source count.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned BUS_W = 32;

  // word offsets (byte address bits 5:2)
  localparam logic [3:0] W_ROUTE = 4'h0;
  localparam logic [3:0] W_MASK  = 4'h1;
  localparam logic [3:0] W_MCLR  = 4'h2;
  localparam logic [3:0] W_MSET  = 4'h3;
  localparam logic [3:0] W_MODE  = 4'h4;
  localparam logic [3:0] W_INV   = 4'h5;
  localparam logic [3:0] W_GUARD = 4'h6;
  localparam logic [3:0] W_PEND  = 4'h7;
  localparam logic [3:0] W_PEND1 = 4'h8;
  localparam logic [3:0] W_RAW   = 4'h9;
  localparam logic [3:0] W_ACK   = 4'hA;
  localparam logic [3:0] W_SOFT  = 4'hB;

  // lowest set bit, scanning from the top so the last hit wins
  function automatic logic [4:0] lowest_set(input logic [BUS_W-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = BUS_W - 1; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         word,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] raw_in,
  input  logic [NUM_SRC-1:0] stat_in,
  output logic [BUS_W-1:0]   rd_data,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mode_q,
  output logic [NUM_SRC-1:0] inv_q,
  output logic [NUM_SRC-1:0] soft_q,
  output logic [NUM_SRC-1:0] ack_pulse
);
  logic [NUM_SRC-1:0] route_q, guard_q;
  logic [NUM_SRC-1:0] d;
  logic [BUS_W-1:0]   unused_hi;

  assign d = wr_data[NUM_SRC-1:0];
  assign unused_hi = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
      inv_q   <= '0;
      guard_q <= '0;
      soft_q  <= '0;
    end else if (wr_en) begin
      case (word)
        W_ROUTE: route_q <= d;
        W_MSET:  mask_q  <= mask_q | d;
        W_MCLR:  mask_q  <= mask_q & ~d;
        W_MODE:  mode_q  <= d;
        W_INV:   inv_q   <= d;
        W_GUARD: guard_q <= d;
        W_SOFT:  soft_q  <= d;
        default: ;
      endcase
    end
  end

  assign ack_pulse = (wr_en && word == W_ACK) ? d : '0;

  always_comb begin
    logic [NUM_SRC-1:0] sel;
    case (word)
      W_ROUTE: sel = route_q;
      W_MASK:  sel = mask_q;
      W_MODE:  sel = mode_q;
      W_INV:   sel = inv_q;
      W_GUARD: sel = guard_q;
      W_PEND:  sel = stat_in;
      W_RAW:   sel = raw_in;
      W_SOFT:  sel = soft_q;
      default: sel = '0;
    endcase
    rd_data = '0;
    rd_data[NUM_SRC-1:0] = sel;
  end

  a_r2_set_bits : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_MSET) |=> ((mask_q & $past(d)) == $past(d)));
  a_r2_clr_bits : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_MCLR) |=> ((mask_q & $past(d)) == '0));
  a_r2_mask_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (word == W_MSET || word == W_MCLR)) |=> $stable(mask_q));
endmodule

// File: rtl/sirq_detect.sv
module sirq_detect #(
  parameter int unsigned NUM_SRC = 28,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] mode_q,
  input  logic [NUM_SRC-1:0] inv_q,
  input  logic [NUM_SRC-1:0] soft_q,
  input  logic [NUM_SRC-1:0] ack_pulse,
  output logic [NUM_SRC-1:0] raw_out,
  output logic [NUM_SRC-1:0] edge_ev,
  output logic [NUM_SRC-1:0] latch_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q     <= '0;
        prev_q     <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        sync_q     <= {sync_q[SYNC_N-2:0], src_in[i]};
        prev_q     <= sync_q[SYNC_N-1];
        latch_q[i] <= (latch_q[i] & ~ack_pulse[i]) | edge_ev[i];
      end
    end

    assign lvl        = sync_q[SYNC_N-1] ^ inv_q[i];
    assign edge_ev[i] = mode_q[i] & lvl & ~(prev_q ^ inv_q[i]);
    assign raw_out[i] = (mode_q[i] ? latch_q[i] : lvl) | soft_q[i];

    a_r7_edge_wins : assert property (@(posedge clk) disable iff (!rst_n)
      edge_ev[i] |=> latch_q[i]);
    a_r5_latch_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q[i] && !ack_pulse[i]) |=> latch_q[i]);
  end
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 28,
  localparam int unsigned IDXW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] stat_in,
  output logic [IDXW-1:0]    idx,
  output logic               vld
);
  logic [BUS_W-1:0] wide;
  logic [4:0]       full;

  always_comb begin
    wide = '0;
    wide[NUM_SRC-1:0] = stat_in;
  end

  assign full = lowest_set(wide);
  assign idx  = full[IDXW-1:0];
  assign vld  = |stat_in;
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 28,
  localparam int unsigned IDXW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic [5:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq_out,
  output logic [IDXW-1:0]    top_idx,
  output logic               top_vld
);
  logic [NUM_SRC-1:0] mask_q, mode_q, inv_q, soft_q, ack_pulse;
  logic [NUM_SRC-1:0] raw_w, stat_w, edge_ev, latch_q;
  logic [1:0]         unused_lsb;

  assign unused_lsb = bus_addr[1:0];
  assign stat_w     = raw_w & mask_q;
  assign irq_out    = |stat_w;

  sirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .word(bus_addr[5:2]),
    .wr_data(bus_wdata), .raw_in(raw_w), .stat_in(stat_w),
    .rd_data(bus_rdata), .mask_q(mask_q), .mode_q(mode_q), .inv_q(inv_q),
    .soft_q(soft_q), .ack_pulse(ack_pulse)
  );

  sirq_detect #(.NUM_SRC(NUM_SRC), .SYNC_N(2)) u_detect (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .mode_q(mode_q),
    .inv_q(inv_q), .soft_q(soft_q), .ack_pulse(ack_pulse),
    .raw_out(raw_w), .edge_ev(edge_ev), .latch_q(latch_q)
  );

  sirq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .stat_in(stat_w), .idx(top_idx), .vld(top_vld)
  );

  a_r11_vld_match : assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == top_vld);
  a_r11_lowest : assert property (@(posedge clk) disable iff (!rst_n)
    top_vld |-> (stat_w[top_idx] &&
                 ((stat_w & ((NUM_SRC'(1) << top_idx) - NUM_SRC'(1))) == '0)));
  a_r9_mask_only : assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w & ~mask_q) == '0);
endmodule

// File: tb/sec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sec_irq_ctrl_bench;
  localparam int N = 28;
  localparam logic [31:0] VM = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, top_vld;
  logic [4:0]  top_idx;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_src, m_mask, m_mode, m_inv, m_soft, m_latch;

  always #4 clk = ~clk;

  sec_irq_ctrl #(.NUM_SRC(N)) u_sec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .top_idx(top_idx), .top_vld(top_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_raw();
    return (((m_mode & m_latch) | (~m_mode & (m_src ^ m_inv))) | m_soft) & VM;
  endfunction

  function automatic logic [31:0] exp_idx(input logic [31:0] s);
    for (int i = 0; i < 32; i++) if (s[i]) return i;
    return 0;
  endfunction

  task automatic check_model(input string tag);
    logic [31:0] v, st;
    st = exp_raw() & m_mask;
    rd(6'h24, v); chk({tag, " R9 raw"}, v, exp_raw());
    rd(6'h1C, v); chk({tag, " R9 masked"}, v, st);
    rd(6'h04, v); chk({tag, " R2 mask"}, v, m_mask);
    chk({tag, " R10 irq"}, {31'd0, irq_out}, {31'd0, st != 0});
    chk({tag, " R11 vld"}, {31'd0, top_vld}, {31'd0, st != 0});
    if (st != 0) chk({tag, " R11 idx"}, {27'd0, top_idx}, exp_idx(st));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(6'(a * 4), v); chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 irq", {31'd0, irq_out}, 32'd0);
    chk("R1 vld", {31'd0, top_vld}, 32'd0);

    // R3 storage and width
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); chk("R3 route", v, VM);
    wr(6'h18, 32'hA5A5_A5A5); rd(6'h18, v); chk("R3 guard", v, 32'h05A5_A5A5);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, v); chk("R3 mode", v, VM);
    wr(6'h14, 32'hF000_1234); rd(6'h14, v); chk("R3 inv", v, 32'h0000_1234);
    wr(6'h10, 0); wr(6'h14, 0);

    // R2 set/clear/ignore
    wr(6'h0C, 32'h0000_0F0F); wr(6'h08, 32'h0000_0003);
    rd(6'h04, v); chk("R2 set then clr", v, 32'h0000_0F0C);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R2 direct write ignored", v, 32'h0000_0F0C);
    wr(6'h0C, 32'h0000_0000); rd(6'h04, v); chk("R2 zero bits no effect", v, 32'h0000_0F0C);

    // R12 write-only words
    rd(6'h08, v); chk("R12 mclr reads 0", v, 0);
    rd(6'h0C, v); chk("R12 mset reads 0", v, 0);
    rd(6'h28, v); chk("R12 ack reads 0", v, 0);
    rd(6'h20, v); chk("R9 word 0x20 reads 0", v, 0);

    // R4 level latency: two edges
    wr(6'h0C, VM);
    @(negedge clk); src_in[5] = 1'b1;
    @(negedge clk); rd(6'h24, v); chk("R4 not after one edge", v & 32'h20, 0);
    @(negedge clk); rd(6'h24, v); chk("R4 after two edges", v & 32'h20, 32'h20);
    chk("R11 idx level", {27'd0, top_idx}, 5);
    wr(6'h14, 32'h40); settle(); rd(6'h24, v); chk("R4 active-low level", v, 32'h60);
    chk("R11 lowest of two", {27'd0, top_idx}, 5);
    // R6 ack on level has no lasting effect
    wr(6'h28, 32'h60); settle(); rd(6'h24, v); chk("R6 level ack no effect", v, 32'h60);
    src_in[5] = 1'b0; wr(6'h14, 0); settle();
    rd(6'h24, v); chk("R4 level follows input", v, 0);

    // R5 edge latch, rising
    wr(6'h10, 32'h18); wr(6'h14, 32'h10);
    settle(); rd(6'h24, v); chk("R5 no spurious edge on polarity", v, 0);
    @(negedge clk); src_in[3] = 1'b1; src_in[4] = 1'b1;
    settle(); rd(6'h24, v); chk("R5 rising latched, rise on inverted ignored", v, 32'h08);
    @(negedge clk); src_in[3] = 1'b0; src_in[4] = 1'b0;
    settle(); rd(6'h24, v); chk("R5 latch holds and falling latched", v, 32'h18);
    chk("R11 idx edge", {27'd0, top_idx}, 3);
    wr(6'h28, 32'h08); settle(); rd(6'h24, v); chk("R6 ack clears edge", v, 32'h10);
    wr(6'h28, 32'h10); settle(); rd(6'h24, v); chk("R6 ack clears second", v, 0);
    chk("R10 irq low", {31'd0, irq_out}, 0);

    // R7 edge and ack in the same cycle
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk);
    wr(6'h28, 32'h08);
    rd(6'h24, v); chk("R7 edge beats ack", v & 32'h08, 32'h08);
    wr(6'h28, 32'h08); src_in[3] = 1'b0; settle();

    // R8 soft trigger
    wr(6'h2C, 32'h0400_0000); rd(6'h24, v); chk("R8 soft pending", v, 32'h0400_0000);
    chk("R8 soft irq", {31'd0, irq_out}, 1);
    chk("R11 idx soft", {27'd0, top_idx}, 26);
    wr(6'h08, 32'h0400_0000); rd(6'h1C, v); chk("R9 masked drops soft", v, 0);
    chk("R10 irq follows mask", {31'd0, irq_out}, 0);

    // random phase from a fresh reset
    @(negedge clk); rst_n = 1'b0; src_in = '0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    m_src = 0; m_mask = 0; m_mode = 0; m_inv = 0; m_soft = 0; m_latch = 0;
    for (int it = 0; it < 400; it++) begin
      logic [31:0] r;
      int op;
      r = $urandom() & VM;
      op = $urandom_range(0, 6);
      case (op)
        0: begin
          logic [31:0] ns;
          ns = ($urandom_range(0, 1) == 1) ? (m_src ^ (32'd1 << $urandom_range(0, N - 1))) : r;
          m_latch = m_latch | (m_mode & (ns ^ m_inv) & ~(m_src ^ m_inv));
          m_src = ns;
          @(negedge clk); src_in = ns[N-1:0];
        end
        1: begin wr(6'h0C, r); m_mask = m_mask | r; end
        2: begin wr(6'h08, r); m_mask = m_mask & ~r; end
        3: begin wr(6'h10, r); m_mode = r; end
        4: begin wr(6'h14, r); m_inv = r; end
        5: begin wr(6'h28, r); m_latch = m_latch & ~r; end
        default: begin
          r = ($urandom_range(0, 3) == 0) ? r : 0;
          wr(6'h2C, r); m_soft = r;
        end
      endcase
      settle();
      check_model("rand");
    end
    finish_run();
  end
endmodule